// File: doc/BRIEF.md
# Dual-Bank DSP Address Generator

This block forms the operand addresses for a DSP datapath that has two data memories, X and Y. It holds eight pointer registers. Each pointer has an offset register and a modifier register with the same index, so there are 24 address-side registers in all. Pointers 0 to 3 form the lower bank and pointers 4 to 7 form the upper bank.

Each cycle the decoder presents one of four request kinds:

- **Idle:** no access.
- **Single:** one address, aimed at X or Y.
- **Dual:** two independent addresses. One comes from each bank, and they target opposite spaces.
- **Long:** one address applied to both spaces. The high word is in X and the low word is in Y.

The block drives one address, one enable and one write strobe per space. It also post-updates the pointers it used, with linear or modulo arithmetic. All address arithmetic finishes within the access cycle.

A move write port loads any pointer, offset or modifier register. The block reports a hazard when a register set is used as a pointer in the instruction right after a move has written it.

Top module: `agu_dual_bank`

## Requirements
- R1: After reset every pointer and offset register is zero and every modifier register is all ones. A first access of any pointer therefore presents address 0, and a +1 update then yields 1.
- R2: A single access (request kind 1) presents the pre-update value of the selected pointer on the space chosen by `a_space` (0 = X, 1 = Y). That space's enable is set and its write strobe equals `a_write`. The other space stays idle, with enable, strobe and address all 0.
- R3: Update modes are encoded 0 = no update, 1 = +1, 2 = -1, 3 = + the paired offset register (signed). The updated pointer is seen from the next cycle on.
- R4: With a modifier of all ones, updates use plain 16-bit two's-complement arithmetic, so 0 - 1 gives 0xFFFF.
- R5: With any other modifier value M, the pointer moves within an aligned buffer of modulus M+1. The buffer base is the pointer with its low bits cleared, over the smallest power of two that is at least M+1. A step past either end wraps by M+1, provided the step size is at most M+1.
- R6: A dual access (request kind 2) presents channel A's address on the space `a_space` with strobe `a_write`, and channel B's address on the other space with strobe `b_write`. Both pointers are post-updated by their own modes.
- R7: A dual access whose two pointers share a bank (pointer index bit 2 equal), or whose two spaces are equal, raises `illegal`. Both enables and both strobes stay low, and neither pointer is updated.
- R8: A long access (request kind 3) presents channel A's pre-update pointer on both X and Y. Both enables are set, both strobes equal `a_write`, and channel A's pointer is updated by its mode.
- R9: The move port writes the pointer (select 0), offset (1) or modifier (2) register at index `mv_idx` at the clock edge. Select 3 writes nothing. A move to a pointer wins over a post-update of that same pointer in the same cycle.
- R10: `hazard` is 1 when an access uses a pointer index that any move wrote in the previous cycle. It is 0 when the move was two or more cycles earlier. A hazard does not block the access.
- R11: With request kind 0 both spaces are idle, all addresses are 0, and no pointer changes, whatever the channel fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_kind | input | 2 | Request kind: 0 idle, 1 single, 2 dual, 3 long |
| a_ptr | input | 3 | Channel A pointer index |
| a_mode | input | 2 | Channel A update mode |
| a_space | input | 1 | Channel A target space (0 X, 1 Y) |
| a_write | input | 1 | Channel A write strobe request |
| b_ptr | input | 3 | Channel B pointer index (dual only) |
| b_mode | input | 2 | Channel B update mode |
| b_space | input | 1 | Channel B target space |
| b_write | input | 1 | Channel B write strobe request |
| mv_en | input | 1 | Move write enable |
| mv_sel | input | 2 | Move target: 0 pointer, 1 offset, 2 modifier, 3 none |
| mv_idx | input | 3 | Move register index |
| mv_data | input | 16 | Move write data |
| x_addr | output | 16 | X memory address |
| x_en | output | 1 | X memory enable |
| x_we | output | 1 | X memory write strobe |
| y_addr | output | 16 | Y memory address |
| y_en | output | 1 | Y memory enable |
| y_we | output | 1 | Y memory write strobe |
| illegal | output | 1 | Dual request breaks the bank or space rule |
| hazard | output | 1 | Pointer used one instruction after a move to it |

## Verification
The assertions check four rules on every cycle:

- An illegal request never drives a strobe.
- A long access always shows the same enabled address on both spaces.
- A move lands in its register even when a post-update competes for it.
- The hazard flag follows a move to the same index and stays quiet otherwise.

Modulo wrapping of +1 and -1 steps is also checked wherever the pointer starts inside its window.

Only the bench's scenarios can show the rest:

- The actual address sequences under each update mode.
- Wrapping at both buffer ends.
- That rejected dual requests leave the pointers untouched.
- That select-3 moves and idle requests change nothing.

// File: rtl/agu_pkg.sv
// Shared encodings for the dual-bank address generator.
package agu_pkg;
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_INC  = 2'd1,
        UPD_DEC  = 2'd2,
        UPD_ADDN = 2'd3
    } upd_mode_e;

    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_SINGLE = 2'd1,
        ACC_DUAL   = 2'd2,
        ACC_LONG   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_OFS  = 2'd1,
        SEL_MOD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/agu_addr_calc.sv
// Post-update arithmetic for one pointer.
// Purely combinational: it takes a pointer, its offset and its modifier plus an
// update mode, and returns the next pointer value.
// Assumes that in modulo mode the step size is no larger than the modulus.
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr_i,
    input  logic [AW-1:0] ofs_i,
    input  logic [AW-1:0] mod_i,
    input  upd_mode_e     mode_i,
    output logic [AW-1:0] next_o
);
    localparam int SW = AW + 2;

    logic [AW-1:0]        win_mask;
    logic signed [SW-1:0] step;
    logic signed [SW-1:0] offs_ext;
    logic signed [SW-1:0] mod_ext;
    logic signed [SW-1:0] moved;
    logic                 linear;

    // Build the window mask: fill every bit below the modifier's top set bit.
    always_comb begin
        win_mask = mod_i;
        for (int s = 1; s < AW; s = s * 2) begin
            win_mask = win_mask | (win_mask >> s);
        end
    end

    // Choose the signed step for the requested mode.
    always_comb begin
        case (mode_i)
            UPD_INC:  step = SW'(1);
            UPD_DEC:  step = -SW'(1);
            UPD_ADDN: step = {{2{ofs_i[AW-1]}}, ofs_i};
            default:  step = '0;
        endcase
    end

    assign linear   = (mod_i == {AW{1'b1}});
    assign offs_ext = $signed({2'b00, ptr_i & win_mask});
    assign mod_ext  = $signed({2'b00, mod_i});

    // Wrap the in-window offset once in either direction, then rebuild the pointer.
    always_comb begin
        moved = offs_ext + step;
        if (moved > mod_ext) begin
            moved = moved - mod_ext - SW'(1);
        end else if (moved < 0) begin
            moved = moved + mod_ext + SW'(1);
        end
        if (linear) begin
            next_o = ptr_i + step[AW-1:0];
        end else begin
            next_o = (ptr_i & ~win_mask) | moved[AW-1:0];
        end
    end

    // A +1 or -1 step that starts inside a modulo window stays inside it.
    always_comb begin
        if (!linear && (mode_i == UPD_INC || mode_i == UPD_DEC) &&
            ((ptr_i & win_mask) <= mod_i)) begin
            a_r5_stays_in_window: assert ((next_o & win_mask) <= mod_i);
        end
    end
endmodule

// File: rtl/agu_regfile.sv
// Pointer, offset and modifier register file.
// The move port takes priority over the two post-update ports. The two
// post-update ports never target the same pointer in a legal dual access.
module agu_regfile
    import agu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NPTR = 8,
    parameter int IDXW = $clog2(NPTR)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mv_en,
    input  reg_sel_e                  mv_sel,
    input  logic [IDXW-1:0]           mv_idx,
    input  logic [AW-1:0]             mv_data,
    input  logic [1:0]                wb_en,
    input  logic [1:0][IDXW-1:0]      wb_idx,
    input  logic [1:0][AW-1:0]        wb_data,
    output logic [NPTR-1:0][AW-1:0]   ptr_q,
    output logic [NPTR-1:0][AW-1:0]   ofs_q,
    output logic [NPTR-1:0][AW-1:0]   mod_q
);
    for (genvar i = 0; i < NPTR; i++) begin : g_set
        logic hit;
        assign hit = mv_en && (mv_idx == IDXW'(i));

        // Pointer: a move first, then channel A write-back, then channel B.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[i] <= '0;
            end else if (hit && mv_sel == SEL_PTR) begin
                ptr_q[i] <= mv_data;
            end else if (wb_en[0] && wb_idx[0] == IDXW'(i)) begin
                ptr_q[i] <= wb_data[0];
            end else if (wb_en[1] && wb_idx[1] == IDXW'(i)) begin
                ptr_q[i] <= wb_data[1];
            end
        end

        // Offset register: loaded only by moves.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ofs_q[i] <= '0;
            end else if (hit && mv_sel == SEL_OFS) begin
                ofs_q[i] <= mv_data;
            end
        end

        // Modifier register: resets to linear mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mod_q[i] <= '1;
            end else if (hit && mv_sel == SEL_MOD) begin
                mod_q[i] <= mv_data;
            end
        end
    end

    // A pointer move lands even when a post-update competes for it.
    a_r9_move_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mv_en) && $past(mv_sel) == SEL_PTR)
        |-> ptr_q[$past(mv_idx)] == $past(mv_data));
endmodule

// File: rtl/agu_hazard.sv
// Write-to-use tracker.
// It remembers which index a move touched in the previous cycle, and flags any
// pointer use of that index in the current cycle. Each cycle is one instruction.
module agu_hazard #(
    parameter int NPTR = 8,
    parameter int IDXW = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mv_en,
    input  logic [IDXW-1:0] mv_idx,
    input  logic            use_a,
    input  logic [IDXW-1:0] a_idx,
    input  logic            use_b,
    input  logic [IDXW-1:0] b_idx,
    output logic            hazard_o
);
    logic            last_v;
    logic [IDXW-1:0] last_idx;

    // Record the previous cycle's move target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_v   <= 1'b0;
            last_idx <= '0;
        end else begin
            last_v   <= mv_en;
            last_idx <= mv_idx;
        end
    end

    assign hazard_o = last_v && ((use_a && a_idx == last_idx) ||
                                 (use_b && b_idx == last_idx));

    // A use right after a move to the same index is flagged.
    a_r10_flag_after_move: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mv_en) && use_a && a_idx == $past(mv_idx)) |-> hazard_o);
    // With no move in the previous cycle there is never a hazard.
    a_r10_quiet_without_move: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mv_en) |-> !hazard_o);
endmodule

// File: rtl/agu_dual_bank.sv
// Dual-bank address generator top.
// It decodes the request kind, selects pointers, checks the bank and space rule
// for dual accesses, drives the X/Y address and strobe ports, and writes back
// post-updated pointers. Assumes the lower half of the indices is one bank and
// the upper half is the other.
module agu_dual_bank
    import agu_pkg::*;
#(
    parameter int AW   = 16,
    parameter int NPTR = 8,
    localparam int IDXW = $clog2(NPTR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      acc_kind,
    input  logic [IDXW-1:0] a_ptr,
    input  logic [1:0]      a_mode,
    input  logic            a_space,
    input  logic            a_write,
    input  logic [IDXW-1:0] b_ptr,
    input  logic [1:0]      b_mode,
    input  logic            b_space,
    input  logic            b_write,
    input  logic            mv_en,
    input  logic [1:0]      mv_sel,
    input  logic [IDXW-1:0] mv_idx,
    input  logic [AW-1:0]   mv_data,
    output logic [AW-1:0]   x_addr,
    output logic            x_en,
    output logic            x_we,
    output logic [AW-1:0]   y_addr,
    output logic            y_en,
    output logic            y_we,
    output logic            illegal,
    output logic            hazard
);
    acc_kind_e                kind;
    logic                     use_a;
    logic                     use_b;
    logic                     go;
    logic [NPTR-1:0][AW-1:0]  ptr_q;
    logic [NPTR-1:0][AW-1:0]  ofs_q;
    logic [NPTR-1:0][AW-1:0]  mod_q;
    logic [1:0][IDXW-1:0]     ch_idx;
    logic [1:0][1:0]          ch_mode;
    logic [1:0][AW-1:0]       ch_addr;
    logic [1:0][AW-1:0]       ch_next;
    logic [1:0]               wb_en;

    assign kind       = acc_kind_e'(acc_kind);
    assign use_a      = (kind != ACC_IDLE);
    assign use_b      = (kind == ACC_DUAL);
    assign illegal    = use_b && ((a_ptr[IDXW-1] == b_ptr[IDXW-1]) || (a_space == b_space));
    assign go         = use_a && !illegal;
    assign ch_idx[0]  = a_ptr;
    assign ch_idx[1]  = b_ptr;
    assign ch_mode[0] = a_mode;
    assign ch_mode[1] = b_mode;
    assign wb_en[0]   = go;
    assign wb_en[1]   = go && use_b;

    // One address calculator per channel.
    for (genvar c = 0; c < 2; c++) begin : g_ch
        assign ch_addr[c] = ptr_q[ch_idx[c]];
        agu_addr_calc #(.AW(AW)) u_calc (
            .ptr_i  (ch_addr[c]),
            .ofs_i  (ofs_q[ch_idx[c]]),
            .mod_i  (mod_q[ch_idx[c]]),
            .mode_i (upd_mode_e'(ch_mode[c])),
            .next_o (ch_next[c])
        );
    end

    agu_regfile #(.AW(AW), .NPTR(NPTR), .IDXW(IDXW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .mv_en   (mv_en),
        .mv_sel  (reg_sel_e'(mv_sel)),
        .mv_idx  (mv_idx),
        .mv_data (mv_data),
        .wb_en   (wb_en),
        .wb_idx  (ch_idx),
        .wb_data (ch_next),
        .ptr_q   (ptr_q),
        .ofs_q   (ofs_q),
        .mod_q   (mod_q)
    );

    agu_hazard #(.NPTR(NPTR), .IDXW(IDXW)) u_haz (
        .clk      (clk),
        .rst_n    (rst_n),
        .mv_en    (mv_en),
        .mv_idx   (mv_idx),
        .use_a    (use_a),
        .a_idx    (a_ptr),
        .use_b    (use_b),
        .b_idx    (b_ptr),
        .hazard_o (hazard)
    );

    // Steer the channel addresses and strobes onto the X and Y ports.
    always_comb begin
        x_addr = '0; x_en = 1'b0; x_we = 1'b0;
        y_addr = '0; y_en = 1'b0; y_we = 1'b0;
        if (go) begin
            if (kind == ACC_LONG) begin
                x_addr = ch_addr[0]; x_en = 1'b1; x_we = a_write;
                y_addr = ch_addr[0]; y_en = 1'b1; y_we = a_write;
            end else begin
                if (a_space) begin
                    y_addr = ch_addr[0]; y_en = 1'b1; y_we = a_write;
                end else begin
                    x_addr = ch_addr[0]; x_en = 1'b1; x_we = a_write;
                end
                if (kind == ACC_DUAL) begin
                    if (b_space) begin
                        y_addr = ch_addr[1]; y_en = 1'b1; y_we = b_write;
                    end else begin
                        x_addr = ch_addr[1]; x_en = 1'b1; x_we = b_write;
                    end
                end
            end
        end
    end

    // A rejected dual request drives no strobe.
    a_r7_illegal_silent: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!x_en && !y_en && !x_we && !y_we));
    // A long access shows one enabled address on both spaces.
    a_r8_long_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd3) |-> (x_en && y_en && x_addr == y_addr && x_we == y_we));
endmodule

// File: tb/test_agu_dual_bank.sv
// Cycle-by-cycle reference model bench for the dual-bank address generator.
module test_agu_dual_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  a_ptr = '0, b_ptr = '0;
    logic [1:0]  a_mode = '0, b_mode = '0;
    logic        a_space = 1'b0, b_space = 1'b0, a_write = 1'b0, b_write = 1'b0;
    logic        mv_en = 1'b0;
    logic [1:0]  mv_sel = '0;
    logic [2:0]  mv_idx = '0;
    logic [15:0] mv_data = '0;
    logic [15:0] x_addr, y_addr;
    logic        x_en, x_we, y_en, y_we, illegal, hazard;

    int applied = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] mr [8];
    logic [15:0] mn [8];
    logic [15:0] mm [8];
    bit          prev_mv = 0;
    logic [2:0]  prev_idx = '0;

    always #5 clk = ~clk;

    agu_dual_bank i_agu_dual_bank (
        .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind),
        .a_ptr(a_ptr), .a_mode(a_mode), .a_space(a_space), .a_write(a_write),
        .b_ptr(b_ptr), .b_mode(b_mode), .b_space(b_space), .b_write(b_write),
        .mv_en(mv_en), .mv_sel(mv_sel), .mv_idx(mv_idx), .mv_data(mv_data),
        .x_addr(x_addr), .x_en(x_en), .x_we(x_we),
        .y_addr(y_addr), .y_en(y_en), .y_we(y_we),
        .illegal(illegal), .hazard(hazard)
    );

    function automatic logic [15:0] mdl_next(logic [15:0] r, logic [15:0] n,
                                             logic [15:0] m, logic [1:0] mode);
        int step;
        int size;
        int off;
        int base;
        step = (mode == 2'd1) ? 1 : (mode == 2'd2) ? -1 :
               (mode == 2'd3) ? int'($signed(n)) : 0;
        if (m == 16'hFFFF) return 16'(int'(r) + step);
        size = 1;
        while (size < int'(m) + 1) size = size * 2;
        off  = int'(r) % size;
        base = int'(r) - off;
        off  = off + step;
        if (off > int'(m)) off = off - int'(m) - 1;
        else if (off < 0) off = off + int'(m) + 1;
        return 16'(base + off);
    endfunction

    task automatic chk(string req, string what, int got, int exp);
        applied++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Apply one cycle: drive, compare against the model mid-cycle, advance the model.
    task automatic cyc(string req, logic [1:0] k,
                       logic [2:0] ap, logic [1:0] am, logic as, logic aw,
                       logic [2:0] bp, logic [1:0] bm, logic bs, logic bw,
                       logic me, logic [1:0] ms, logic [2:0] mi, logic [15:0] md);
        bit legal, go, ehz;
        logic [15:0] ex_xa, ex_ya, na, nb;
        bit ex_xe, ex_xw, ex_ye, ex_yw;
        acc_kind = k; a_ptr = ap; a_mode = am; a_space = as; a_write = aw;
        b_ptr = bp; b_mode = bm; b_space = bs; b_write = bw;
        mv_en = me; mv_sel = ms; mv_idx = mi; mv_data = md;
        legal = !(k == 2'd2 && (ap[2] == bp[2] || as == bs));
        go = (k != 2'd0) && legal;
        ex_xa = '0; ex_ya = '0; ex_xe = 0; ex_xw = 0; ex_ye = 0; ex_yw = 0;
        if (go) begin
            if (k == 2'd3) begin
                ex_xa = mr[ap]; ex_ya = mr[ap]; ex_xe = 1; ex_ye = 1; ex_xw = aw; ex_yw = aw;
            end else begin
                if (as) begin ex_ya = mr[ap]; ex_ye = 1; ex_yw = aw; end
                else    begin ex_xa = mr[ap]; ex_xe = 1; ex_xw = aw; end
                if (k == 2'd2) begin
                    if (bs) begin ex_ya = mr[bp]; ex_ye = 1; ex_yw = bw; end
                    else    begin ex_xa = mr[bp]; ex_xe = 1; ex_xw = bw; end
                end
            end
        end
        ehz = prev_mv && ((k != 2'd0 && ap == prev_idx) || (k == 2'd2 && bp == prev_idx));
        #4;
        chk(req, "x_addr", int'(x_addr), int'(ex_xa));
        chk(req, "x_en", int'(x_en), int'(ex_xe));
        chk(req, "x_we", int'(x_we), int'(ex_xw));
        chk(req, "y_addr", int'(y_addr), int'(ex_ya));
        chk(req, "y_en", int'(y_en), int'(ex_ye));
        chk(req, "y_we", int'(y_we), int'(ex_yw));
        chk("R7", "illegal", int'(illegal), int'(!legal));
        chk("R10", "hazard", int'(hazard), int'(ehz));
        na = mdl_next(mr[ap], mn[ap], mm[ap], am);
        nb = mdl_next(mr[bp], mn[bp], mm[bp], bm);
        if (go) begin
            mr[ap] = na;
            if (k == 2'd2) mr[bp] = nb;
        end
        if (me) begin
            case (ms)
                2'd0: mr[mi] = md;
                2'd1: mn[mi] = md;
                2'd2: mm[mi] = md;
                default: ;
            endcase
        end
        prev_mv = me;
        prev_idx = mi;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(string req);
        cyc(req, 2'd0, 3'd0, 2'd1, 0, 0, 3'd4, 2'd1, 1, 0, 0, 2'd0, 3'd0, 16'h0);
    endtask

    task automatic mv(string req, logic [1:0] s, logic [2:0] i, logic [15:0] d);
        cyc(req, 2'd0, 3'd0, 2'd0, 0, 0, 3'd4, 2'd0, 1, 0, 1, s, i, d);
    endtask

    task automatic one(string req, logic [2:0] p, logic [1:0] m, logic sp, logic w);
        cyc(req, 2'd1, p, m, sp, w, 3'd0, 2'd0, 0, 0, 0, 2'd0, 3'd0, 16'h0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin mr[i] = '0; mn[i] = '0; mm[i] = 16'hFFFF; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state and R4 linear wrap below zero
        one("R1", 3'd0, 2'd1, 0, 0);
        one("R1", 3'd0, 2'd0, 1, 0);
        one("R4", 3'd7, 2'd2, 0, 0);
        one("R4", 3'd7, 2'd0, 1, 1);
        // R9 moves, R3 modes, R2 single access on both spaces
        mv("R9", 2'd0, 3'd0, 16'h0100);
        mv("R9", 2'd1, 3'd0, 16'h0010);
        idle("R11");
        one("R3", 3'd0, 2'd3, 0, 1);
        one("R3", 3'd0, 2'd2, 0, 0);
        one("R2", 3'd0, 2'd0, 1, 0);
        mv("R9", 2'd3, 3'd0, 16'hDEAD);
        idle("R11");
        one("R9", 3'd0, 2'd0, 0, 0);
        // R5 modulo 5 buffer, wrap at both ends and with an offset step
        mv("R5", 2'd2, 3'd1, 16'd4);
        mv("R5", 2'd0, 3'd1, 16'h0023);
        idle("R5");
        one("R5", 3'd1, 2'd1, 0, 0);
        one("R5", 3'd1, 2'd1, 0, 0);
        one("R5", 3'd1, 2'd2, 0, 0);
        one("R5", 3'd1, 2'd0, 0, 0);
        mv("R5", 2'd1, 3'd1, 16'd3);
        idle("R5");
        one("R5", 3'd1, 2'd3, 1, 0);
        one("R5", 3'd1, 2'd0, 1, 0);
        mv("R5", 2'd2, 3'd2, 16'd0);
        mv("R5", 2'd0, 3'd2, 16'h0055);
        idle("R5");
        one("R5", 3'd2, 2'd1, 0, 0);
        one("R5", 3'd2, 2'd0, 0, 0);
        // R6 dual accesses with independent strobes
        mv("R6", 2'd0, 3'd4, 16'h0200);
        mv("R6", 2'd0, 3'd5, 16'h0300);
        idle("R6");
        cyc("R6", 2'd2, 3'd2, 2'd1, 0, 0, 3'd5, 2'd2, 1, 1, 0, 2'd0, 3'd0, 16'h0);
        cyc("R6", 2'd2, 3'd5, 2'd0, 0, 1, 3'd0, 2'd1, 1, 0, 0, 2'd0, 3'd0, 16'h0);
        // R7 illegal: same bank, then same space; pointers must not move
        cyc("R7", 2'd2, 3'd1, 2'd1, 0, 1, 3'd3, 2'd1, 1, 1, 0, 2'd0, 3'd0, 16'h0);
        cyc("R7", 2'd2, 3'd1, 2'd1, 0, 1, 3'd5, 2'd1, 0, 1, 0, 2'd0, 3'd0, 16'h0);
        one("R7", 3'd5, 2'd0, 0, 0);
        one("R7", 3'd1, 2'd0, 1, 0);
        // R8 long access
        cyc("R8", 2'd3, 3'd4, 2'd1, 0, 1, 3'd0, 2'd0, 0, 0, 0, 2'd0, 3'd0, 16'h0);
        cyc("R8", 2'd3, 3'd4, 2'd0, 1, 0, 3'd0, 2'd0, 0, 0, 0, 2'd0, 3'd0, 16'h0);
        // R10 hazard: use right after move, then two instructions later
        mv("R10", 2'd0, 3'd6, 16'h0040);
        one("R10", 3'd6, 2'd1, 0, 0);
        mv("R10", 2'd1, 3'd6, 16'd2);
        idle("R10");
        one("R10", 3'd6, 2'd3, 1, 0);
        mv("R10", 2'd1, 3'd5, 16'd1);
        cyc("R10", 2'd2, 3'd0, 2'd0, 0, 0, 3'd5, 2'd3, 1, 0, 0, 2'd0, 3'd0, 16'h0);
        // R9 move beats post-update on the same pointer
        idle("R9");
        cyc("R9", 2'd1, 3'd4, 2'd1, 0, 0, 3'd0, 2'd0, 0, 0, 1, 2'd0, 3'd4, 16'h0777);
        idle("R9");
        one("R9", 3'd4, 2'd0, 0, 0);
        // R11 idle requests with live channel fields change nothing
        cyc("R11", 2'd0, 3'd3, 2'd3, 1, 1, 3'd6, 2'd2, 0, 1, 0, 2'd0, 3'd0, 16'h0);
        cyc("R11", 2'd0, 3'd3, 2'd3, 1, 1, 3'd6, 2'd2, 0, 1, 0, 2'd0, 3'd0, 16'h0);
        one("R11", 3'd3, 2'd0, 0, 0);
        one("R11", 3'd6, 2'd0, 1, 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end
endmodule